// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a synchronous host and an asynchronous static RAM whose data word is split into byte lanes, each lane gated by its own active-low enable. The host asks for one access at a time: an address, write data, a per-byte mask (1 = lane included) and a write flag. The controller runs the memory strobes through three timed phases. It first presents the address. It then holds chip enable and the lane enables low, together with either output enable (read) or the write strobe (write). Last, it releases the strobes while the address and write data stay put. It ends each access with a one-cycle completion pulse, which carries the read data on a read.

Every phase length is worked out when the block is elaborated. Each is the ceiling of a nanosecond minimum over `CLK_PERIOD_NS`, never less than one cycle. The active phase of a write is long enough for the write-pulse minimum and for the enable-to-end-of-write minimum. It is also long enough for the memory's output turn-off delay after the write strobe falls plus the data setup time, because the write drivers stay off during that turn-off delay. A write that follows a read stretches its setup phase so that the memory has released the bus. The address and write data are held in registers, and the strobes are decoded from the registered phase, so each strobe changes only at clock edges.

Back-pressure: the request side is valid/ready. `req_ready` is high only while the controller is idle. A request is taken on the edge where `req_valid` and `req_ready` are both high, and its fields are sampled on that edge only. The completion side cannot be held off: `rsp_valid` is high for exactly one cycle, and `rsp_rdata` keeps its value until the next read completes.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held and just after it, `req_ready` is 1, `rsp_valid` is 0, `sram_ce_n`, `sram_oe_n`, `sram_we_n` and every `sram_be_n` bit are 1, and `sram_dq_oe` is 0.
- R2: `req_ready` is 0 from the cycle after a request is taken until the cycle after its `rsp_valid` pulse, when it is 1 again. While idle, chip enable stays high and the data drivers stay off.
- R3: A read holds `sram_ce_n` and `sram_oe_n` low for exactly ceil(55 ns / period) cycles (11 at 5 ns) with the address stable. Data is captured at the end of that window, and `rsp_valid` is seen 13 cycles after the accepting edge at 5 ns.
- R4: Mask bit b drives `sram_be_n[b]` low during the active phase. Bit 0 is data bits 7:0 and bit 1 is bits 15:8. On a read, a lane whose mask bit is 0 returns 8'h00 in `rsp_rdata`.
- R5: A write holds `sram_we_n` and `sram_ce_n` low for max(ceil(40/p), ceil(45/p), ceil(25/p)+ceil(25/p)) cycles (10 at 5 ns), and `sram_oe_n` stays high for the whole write.
- R6: During a write, `sram_dq_oe` is 0 for the first ceil(25/p) cycles (5) of the write-strobe-low window and is 1 for the remaining cycles (at least 5) up to the strobe's rise. Only lanes whose mask bit is 1 change in memory.
- R7: A write that directly follows a read has a setup phase of ceil(25/p) cycles (5) instead of 1, so `rsp_valid` comes 16 cycles after the accepting edge rather than 12.
- R8: A write not preceded by a read completes with `rsp_valid` 12 cycles after the accepting edge at 5 ns, so the whole write cycle is at least 55 ns.
- R9: A write with mask 2'b00 asserts no lane enable and leaves the addressed word unchanged.
- R10: `rsp_valid` is a single-cycle pulse; it is 0 in the cycle after it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Lane mask, 1 = lane included, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, unmasked lanes zero |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_be_n | output | DATA_W/8 | Lane enables, active low |
| sram_dq_out | output | DATA_W | Data driven toward memory |
| sram_dq_oe | output | 1 | Enables the data drivers |
| sram_dq_in | input | DATA_W | Data returned by memory |

## Verification
A phase counter loaded with the wrong length shows up at once at the ports. It shows as a strobe-low window of the wrong width and as a `rsp_valid` pulse that comes early or late, within the same access. A read window that is too short lets the bench's memory model return a poison value before its access time, so the error appears in `rsp_rdata` at the end of that read. A lost read-to-write history shows on the next write as a 12-cycle instead of a 16-cycle completion. Drivers that are switched on too early appear in the first write-strobe cycle. A wrong lane decode is seen in the read-back of the next access.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // Cycles needed to cover a nanosecond minimum, never fewer than one.
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expired
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - 1'b1;
  end

  assign expired = (count == '0);

endmodule

// File: rtl/asram_req_regs.sv
module asram_req_regs #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [LANES-1:0]  in_mask,
  input  logic              sample,
  input  logic [DATA_W-1:0] rd_bus,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  mask,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_write <= 1'b0;
      addr     <= '0;
      wdata    <= '0;
      mask     <= '0;
    end else if (capture) begin
      is_write <= in_write;
      addr     <= in_addr;
      wdata    <= in_wdata;
      mask     <= in_mask;
    end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata[b*8 +: 8] <= 8'h00;
      else if (sample) rdata[b*8 +: 8] <= mask[b] ? rd_bus[b*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_RC_NS       = 55,  // read cycle
  parameter int T_AA_NS       = 55,  // access from address
  parameter int T_OA_NS       = 30,  // access from output enable
  parameter int T_WP_NS       = 40,  // write strobe width
  parameter int T_CW_NS       = 45,  // enable to end of write
  parameter int T_DS_NS       = 25,  // data setup to strobe rise
  parameter int T_WZ_NS       = 25,  // memory turn-off after strobe falls
  parameter int T_RZ_NS       = 25,  // memory turn-off after read ends
  parameter int T_WC_NS       = 55   // write cycle
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_mask,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ADDR_W-1:0]      sram_addr,
  output logic                   sram_ce_n,
  output logic                   sram_oe_n,
  output logic                   sram_we_n,
  output logic [DATA_W/8-1:0]    sram_be_n,
  output logic [DATA_W-1:0]      sram_dq_out,
  output logic                   sram_dq_oe,
  input  logic [DATA_W-1:0]      sram_dq_in
);

  localparam int LANES   = DATA_W / 8;
  localparam int RD_ACT  = imax(imax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_OA_NS, CLK_PERIOD_NS)),
                                ns_to_cyc(T_RC_NS, CLK_PERIOD_NS) - 2);
  localparam int WZ_CYC  = ns_to_cyc(T_WZ_NS, CLK_PERIOD_NS);
  localparam int DS_CYC  = ns_to_cyc(T_DS_NS, CLK_PERIOD_NS);
  localparam int WR_ACT  = imax(imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_CW_NS, CLK_PERIOD_NS)),
                                WZ_CYC + DS_CYC);
  localparam int WR_HOLD = imax(1, ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - 1 - WR_ACT);
  localparam int RZ_CYC  = ns_to_cyc(T_RZ_NS, CLK_PERIOD_NS);
  localparam int MAX_LEN = imax(imax(RD_ACT, WR_ACT), imax(WR_HOLD, RZ_CYC));
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_ACT - 1);
  localparam logic [CNT_W-1:0] WR_LD  = CNT_W'(WR_ACT - 1);
  localparam logic [CNT_W-1:0] WH_LD  = CNT_W'(WR_HOLD - 1);
  localparam logic [CNT_W-1:0] RZ_LD  = CNT_W'(RZ_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_TH = CNT_W'(WR_ACT - WZ_CYC);

  phase_e             phase, phase_nxt;
  logic               tmr_load, tmr_expired;
  logic [CNT_W-1:0]   tmr_val, tmr_count;
  logic               capture, sample, done;
  logic               after_read;
  logic               is_write;
  logic [LANES-1:0]   mask;
  logic [DATA_W-1:0]  wdata;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .count    (tmr_count),
    .expired  (tmr_expired)
  );

  asram_req_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .in_write (req_write),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .in_mask  (req_mask),
    .sample   (sample),
    .rd_bus   (sram_dq_in),
    .is_write (is_write),
    .addr     (sram_addr),
    .wdata    (wdata),
    .mask     (mask),
    .rdata    (rsp_rdata)
  );

  // Phase sequencing; each phase ends when the loaded count reaches zero.
  always_comb begin
    phase_nxt = phase;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    capture   = 1'b0;
    sample    = 1'b0;
    done      = 1'b0;
    unique case (phase)
      PH_IDLE: if (req_valid) begin
        capture   = 1'b1;
        phase_nxt = PH_SETUP;
        tmr_load  = 1'b1;
        tmr_val   = (req_write && after_read) ? RZ_LD : '0;
      end
      PH_SETUP: if (tmr_expired) begin
        phase_nxt = PH_ACTIVE;
        tmr_load  = 1'b1;
        tmr_val   = is_write ? WR_LD : RD_LD;
      end
      PH_ACTIVE: if (tmr_expired) begin
        phase_nxt = PH_HOLD;
        tmr_load  = 1'b1;
        tmr_val   = is_write ? WH_LD : '0;
        sample    = !is_write;
      end
      PH_HOLD: if (tmr_expired) begin
        phase_nxt = PH_IDLE;
        done      = 1'b1;
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      after_read <= 1'b0;
    end else begin
      phase <= phase_nxt;
      if (done) after_read <= !is_write;
    end
  end

  logic active;
  assign active     = (phase == PH_ACTIVE);
  assign req_ready  = (phase == PH_IDLE);
  assign rsp_valid  = done;
  assign sram_ce_n  = !active;
  assign sram_oe_n  = !(active && !is_write);
  assign sram_we_n  = !(active && is_write);
  assign sram_dq_out = wdata;
  assign sram_dq_oe = is_write &&
                      ((active && (tmr_count < DRV_TH)) || (phase == PH_HOLD));

  for (genvar b = 0; b < LANES; b++) begin : g_be
    assign sram_be_n[b] = !(active && mask[b]);
  end

endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic [LANES-1:0]  sram_be_n,
  input logic              sram_dq_oe
);

  // R5
  no_oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  // R6
  no_early_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> !sram_dq_oe);

  // R6
  no_drive_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  // R10
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && !sram_dq_oe));

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));

  // R4
  lane_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&sram_be_n) |-> !sram_ce_n);

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(DATA_W/8)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_be_n  (sram_be_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/async_sram_ctrl_tb.sv
module async_sram_ctrl_tb;

  localparam int AW = 8;
  localparam int DW = 16;
  // Expected figures at a 5 ns clock, from the nanosecond minimums.
  localparam int RD_WIN  = 11;  // 55 ns
  localparam int WE_WIN  = 10;  // 25 ns off + 25 ns setup
  localparam int OFF_WIN = 5;   // 25 ns
  localparam int RD_LAT  = 13;
  localparam int WR_LAT  = 12;
  localparam int WAR_LAT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_mask = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [1:0]    sram_be_n;
  logic [DW-1:0] sram_dq_out, sram_dq_in;

  async_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(5)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_be_n(sram_be_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // Memory model: write lanes while strobe low and data driven; read data
  // is valid only once chip and output enable have been low for RD_WIN cycles.
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int            acc;
  always @(posedge clk) begin
    if (!sram_ce_n && !sram_we_n && sram_dq_oe)
      for (int b = 0; b < 2; b++)
        if (!sram_be_n[b]) mem[sram_addr][b*8 +: 8] <= sram_dq_out[b*8 +: 8];
    if (sram_ce_n || sram_oe_n) acc <= 0;
    else                        acc <= acc + 1;
  end
  always_comb begin
    sram_dq_in = 16'hBAD0;
    if (!sram_ce_n && !sram_oe_n && acc >= RD_WIN - 1)
      for (int b = 0; b < 2; b++)
        sram_dq_in[b*8 +: 8] = sram_be_n[b] ? 8'hEE : mem[sram_addr][b*8 +: 8];
  end

  int checks = 0, errors = 0;
  int lat, we_cnt, drv_cnt, nodrv_cnt, ce_cnt;
  bit oe_seen, be_seen, ready_bad, early_drv;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic collect();
    if (!sram_we_n) begin
      we_cnt++;
      if (sram_dq_oe) drv_cnt++;
      else begin nodrv_cnt++; if (drv_cnt != 0) early_drv = 1; end
    end
    if (!sram_ce_n) ce_cnt++;
    if (!sram_oe_n && req_write) oe_seen = 1;
    if (sram_be_n != 2'b11) be_seen = 1;
    if (!rsp_valid && req_ready) ready_bad = 1;
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [1:0] m);
    lat = 0; we_cnt = 0; drv_cnt = 0; nodrv_cnt = 0; ce_cnt = 0;
    oe_seen = 0; be_seen = 0; ready_bad = 0; early_drv = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~d;
    lat = 1;
    collect();
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
      collect();
    end
    @(negedge clk);
    chk(!rsp_valid, "R10", rsp_valid, 0);
    chk(req_ready && !ready_bad, "R2", req_ready, 1);
  endtask

  task automatic t_reset();
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 handshake", {req_ready, rsp_valid}, 2'b10);
    chk({sram_ce_n, sram_oe_n, sram_we_n, sram_be_n} === 5'b11111 && sram_dq_oe === 1'b0,
        "R1 strobes", {sram_ce_n, sram_oe_n, sram_we_n, sram_be_n, sram_dq_oe}, 6'b111110);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [1:0] m, input int exp_lat);
    issue(1'b1, a, d, m);
    chk(lat == exp_lat, (exp_lat == WAR_LAT) ? "R7 latency" : "R8 latency", lat, exp_lat);
    chk(we_cnt == WE_WIN && ce_cnt == WE_WIN, "R5 strobe width", we_cnt, WE_WIN);
    chk(!oe_seen, "R5 oe high", oe_seen, 0);
    chk(nodrv_cnt == OFF_WIN && drv_cnt == WE_WIN - OFF_WIN && !early_drv,
        "R6 drive window", nodrv_cnt, OFF_WIN);
    if (m == 2'b00) chk(!be_seen, "R9 no lane", be_seen, 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [1:0] m,
                        input logic [DW-1:0] exp, input string req);
    issue(1'b0, a, '0, m);
    chk(lat == RD_LAT, "R3 latency", lat, RD_LAT);
    chk(ce_cnt == RD_WIN, "R3 strobe width", ce_cnt, RD_WIN);
    chk(rsp_rdata == exp, req, rsp_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(8'h10, 16'hA1B2, 2'b11, WR_LAT);             // R8
    t_read (8'h10, 2'b11, 16'hA1B2, "R3 data");
    t_write(8'h10, 16'h77CC, 2'b01, WAR_LAT);            // R7, R6 lower lane only
    t_write(8'h10, 16'h3355, 2'b10, WR_LAT);             // R8, R6 upper lane only
    t_read (8'h10, 2'b11, 16'h33CC, "R6 lanes");
    t_read (8'h10, 2'b01, 16'h00CC, "R4 low mask");
    t_read (8'h10, 2'b10, 16'h3300, "R4 high mask");
    t_write(8'h10, 16'hFFFF, 2'b00, WAR_LAT);            // R9
    t_read (8'h10, 2'b11, 16'h33CC, "R9 unchanged");
    t_write(8'h20, 16'h1234, 2'b11, WAR_LAT);
    t_write(8'h21, 16'h5678, 2'b11, WR_LAT);
    t_read (8'h20, 2'b11, 16'h1234, "R3 word a");
    t_read (8'h21, 2'b11, 16'h5678, "R3 word b");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule